// File: doc/BRIEF.md
# Gated Retriggerable One-Shot Pulse Generator

This block is a fully synchronous, retriggerable monostable. It has one output channel. Three control levels arrive from outside the clock domain. Each one passes through a synchroniser before the block looks for edges on it:

- a gate that enables the block when low (`gate_lo_i`);
- a gate that enables the block when high (`gate_hi_i`);
- an active-low clear (`clr_n_i`).

A pulse starts when the enable condition becomes true. The enable condition is all three of these at once: `gate_lo_i` low, `gate_hi_i` high and `clr_n_i` high. It becomes true in one of three ways: the high gate rises, the low gate falls, or the clear is released. A pulse on `pulse_o` lasts the number of clock cycles on `dur_i`, taken at the cycle of the trigger. This count replaces an analog timing network.

A new trigger during a pulse reloads the count, so repeated triggers can hold the output high indefinitely. A low clear ends any pulse and blocks new ones. `pulse_n_o` is always the complement of `pulse_o`. For a dual part, instantiate the block twice.

Top module: `oneshot_gate`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pulse_o` is 0 and `pulse_n_o` is 1 until a qualifying trigger is seen.
- R2: In every cycle `pulse_n_o` equals the inverse of `pulse_o`.
- R3: A rising `gate_hi_i` while `gate_lo_i` is low and `clr_n_i` is high starts a pulse.
- R4: A falling `gate_lo_i` while `gate_hi_i` is high and `clr_n_i` is high starts a pulse.
- R5: A rising `clr_n_i` while `gate_lo_i` is low and `gate_hi_i` is high starts a pulse.
- R6: Suppose an input change is applied between clock edges. Then `pulse_o` rises on the third rising edge after the change. It stays high for exactly N cycles, where N is the value of `dur_i` at that third edge. N = 0 gives no pulse.
- R7: A qualifying trigger during a pulse restarts the count from that trigger with the current `dur_i`, which extends the pulse.
- R8: A low `clr_n_i` forces `pulse_o` low by the third rising edge after the change, and the pulse in progress ends. Gate edges seen while the clear is low start nothing. A trigger edge and a clear that reach the block in the same cycle give no pulse.
- R9: Steady gate and clear levels never start a pulse, including levels held across reset. With `gate_lo_i` high or `gate_hi_i` low, no gate activity starts a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gate_lo_i | input | 1 | Enable gate, active low; its falling edge triggers |
| gate_hi_i | input | 1 | Enable gate, active high; its rising edge triggers |
| clr_n_i | input | 1 | Active-low clear; its release triggers when both gates are enabled |
| dur_i | input | DUR_W | Pulse length in clock cycles, sampled on each trigger |
| pulse_o | output | 1 | One-shot output, active high |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
Two pairs of events can meet in one cycle.

- **Trigger and clear.** The bench drives a rising high gate and a falling clear at the same instant, so both cross the synchroniser together. It expects no pulse at all. It also drops the clear partway through a running pulse and checks that the measured width is cut to the cycles before the clear took effect.
- **Retrigger and a running count.** The bench issues a second edge while the count is still running. The measured width must be the span from the first rise to the end of the second full duration.

Random stimulus then mixes all of these, and a bench model predicts the output cycle by cycle.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Synchronised control levels, in the order they are packed.
  typedef struct packed {
    logic gate_lo;
    logic gate_hi;
    logic clr_n;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // True when both gates enable and the clear is released.
  function automatic logic ctl_open(input ctl_t c);
    return !c.gate_lo && c.gate_hi && c.clr_n;
  endfunction

endpackage

// File: rtl/oneshot_rst_sync.sv
module oneshot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q_n = chain_q[STAGES-1];

endmodule

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_d;

    always_comb begin
      stg_d = {stg_q[STAGES-2:0], d_i[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= '0;
      end else begin
        stg_q <= stg_d;
      end
    end

    assign q_o[i] = stg_q[STAGES-1];
  end

endmodule

// File: rtl/oneshot_qual.sv
module oneshot_qual
  import oneshot_pkg::*;
#(
  parameter int ARM_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  ctl_t lvl_i,
  output logic trig_o,
  output logic clr_o
);

  localparam int AW = $clog2(ARM_CYCLES + 1);

  ctl_t          prev_q;
  ctl_t          prev_d;
  logic [AW-1:0] arm_q;
  logic [AW-1:0] arm_d;
  logic          arm_en;
  logic          armed;
  logic          hi_rise;
  logic          lo_fall;
  logic          clr_rise;

  // Edges are only trusted once the pipeline holds real samples.
  always_comb begin
    armed    = (arm_q == AW'(ARM_CYCLES));
    arm_en   = !armed;
    arm_d    = arm_q + AW'(1);
    prev_d   = lvl_i;
    hi_rise  = lvl_i.gate_hi && !prev_q.gate_hi;
    lo_fall  = !lvl_i.gate_lo && prev_q.gate_lo;
    clr_rise = lvl_i.clr_n && !prev_q.clr_n;
    trig_o   = armed && ctl_open(lvl_i) && (hi_rise || lo_fall || clr_rise);
    clr_o    = !lvl_i.clr_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '0;
    end else if (arm_en) begin
      arm_q <= arm_d;
    end
  end

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             clr_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic [DUR_W-1:0] remain_o,
  output logic             pulse_o,
  output logic             pulse_n_o
);

  logic [DUR_W-1:0] cnt_q;
  logic [DUR_W-1:0] cnt_d;
  logic             cnt_en;
  logic             q_q;
  logic             q_d;

  always_comb begin
    cnt_en = clr_i || trig_i || (cnt_q != '0);
    if (clr_i) begin
      cnt_d = '0;
    end else if (trig_i) begin
      cnt_d = dur_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - DUR_W'(1);
    end else begin
      cnt_d = cnt_q;
    end
    q_d = (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  assign remain_o  = cnt_q;
  assign pulse_o   = q_q;
  assign pulse_n_o = ~q_q;

endmodule

// File: rtl/oneshot_gate.sv
module oneshot_gate
  import oneshot_pkg::*;
#(
  parameter int DUR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_lo_i,
  input  logic             gate_hi_i,
  input  logic             clr_n_i,
  input  logic [DUR_W-1:0] dur_i,
  output logic             pulse_o,
  output logic             pulse_n_o
);

  localparam int ARM_CYCLES = SYNC_STAGES + 1;

  logic             rst_q_n;
  ctl_t             raw;
  ctl_t             lvl;
  logic             trig;
  logic             clr_act;
  logic [DUR_W-1:0] remain;

  assign raw.gate_lo = gate_lo_i;
  assign raw.gate_hi = gate_hi_i;
  assign raw.clr_n   = clr_n_i;

  oneshot_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  oneshot_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d_i   (raw),
    .q_o   (lvl)
  );

  oneshot_qual #(.ARM_CYCLES(ARM_CYCLES)) i_qual (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .lvl_i  (lvl),
    .trig_o (trig),
    .clr_o  (clr_act)
  );

  oneshot_timer #(.DUR_W(DUR_W)) i_timer (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .trig_i    (trig),
    .clr_i     (clr_act),
    .dur_i     (dur_i),
    .remain_o  (remain),
    .pulse_o   (pulse_o),
    .pulse_n_o (pulse_n_o)
  );

endmodule

// File: rtl/oneshot_gate_chk.sv
module oneshot_gate_chk #(
  parameter int DUR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig,
  input logic             clr_act,
  input logic             pulse,
  input logic [DUR_W-1:0] dur,
  input logic [DUR_W-1:0] remain
);

  AST_CLEAR_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> !pulse); // R8

  AST_TRIG_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !clr_act && dur != '0) |=> (pulse && remain == $past(dur))); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (remain != '0 && !trig && !clr_act) |=> (remain == $past(remain) - DUR_W'(1))); // R6

  AST_RISE_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(trig)); // R9

  AST_RETRIG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && pulse && !clr_act) |=> (remain == $past(dur))); // R7

endmodule

bind oneshot_gate oneshot_gate_chk #(.DUR_W(DUR_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .trig    (trig),
  .clr_act (clr_act),
  .pulse   (pulse_o),
  .dur     (dur_i),
  .remain  (remain)
);

// File: tb/test_oneshot_gate.sv
`timescale 1ns/1ps
module test_oneshot_gate;

  localparam int DUR_W = 8;

  logic             clk;
  logic             rst_n;
  logic             gate_lo;
  logic             gate_hi;
  logic             clr_n;
  logic [DUR_W-1:0] dur;
  logic             pulse_o;
  logic             pulse_n_o;

  int    n_run;
  int    n_fail;
  int    cyc;
  bit    run;
  bit    exp_q;
  string cur_req;

  oneshot_gate #(.DUR_W(DUR_W), .SYNC_STAGES(2)) i_oneshot_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_lo_i (gate_lo),
    .gate_hi_i (gate_hi),
    .clr_n_i   (clr_n),
    .dur_i     (dur),
    .pulse_o   (pulse_o),
    .pulse_n_o (pulse_n_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // Enable condition: low gate low, high gate high, clear released.
  function automatic bit opened(input logic [2:0] v);
    return !v[2] && v[1] && v[0];
  endfunction

  // Reference model: pulse starts when the enable condition becomes true
  // at the block after two synchroniser stages; clear empties the count.
  logic [2:0] h0, h1, hp;
  int unsigned rem;
  always @(posedge clk) begin
    bit now_open;
    bit was_open;
    now_open = opened(h1);
    was_open = opened(hp);
    if (!run || !h1[0]) rem = 0;
    else if (now_open && !was_open) rem = dur;
    else if (rem != 0) rem = rem - 1;
    hp = h1;
    h1 = h0;
    h0 = {gate_lo, gate_hi, clr_n};
    exp_q = (rem != 0);
  end

  always @(negedge clk) begin
    chk(pulse_n_o === ~pulse_o, "R2", int'(pulse_n_o), int'(~pulse_o));
    if (run) chk(pulse_o === exp_q, cur_req, int'(pulse_o), int'(exp_q));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", cyc, 100000);
      summary();
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Observe the output for 16 cycles after a stimulus applied at a negedge.
  task automatic measure(input int lat, input int width, input string req);
    int first;
    int cnt;
    first = -1;
    cnt   = 0;
    for (int n = 1; n <= 16; n++) begin
      @(negedge clk);
      if (pulse_o) begin
        cnt++;
        if (first < 0) first = n;
      end
    end
    chk(cnt == width, req, cnt, width);
    if (width > 0) chk(first == lat, req, first, lat);
  endtask

  initial begin
    int first;
    int cnt;
    n_run   = 0;
    n_fail  = 0;
    cyc     = 0;
    run     = 1'b0;
    cur_req = "R1";
    // Gates open and clear released through reset: must not trigger.
    rst_n   = 1'b0;
    gate_lo = 1'b0;
    gate_hi = 1'b1;
    clr_n   = 1'b1;
    dur     = 8'd5;
    wait_n(3);
    chk(pulse_o === 1'b0, "R1", int'(pulse_o), 0);
    chk(pulse_n_o === 1'b1, "R1", int'(pulse_n_o), 1);
    rst_n = 1'b1;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      chk(pulse_o === 1'b0, "R9", int'(pulse_o), 0);
    end
    chk(pulse_n_o === 1'b1, "R1", int'(pulse_n_o), 1);
    run = 1'b1;

    // R3: high gate rises with low gate low
    cur_req = "R3";
    gate_hi = 1'b0;
    wait_n(5);
    dur     = 8'd5;
    gate_hi = 1'b1;
    measure(3, 5, "R3");

    // R4: low gate falls with high gate high
    cur_req = "R4";
    gate_lo = 1'b1;
    wait_n(4);
    dur     = 8'd3;
    gate_lo = 1'b0;
    measure(3, 3, "R4");

    // R5: clear released with both gates enabled
    cur_req = "R5";
    clr_n = 1'b0;
    wait_n(4);
    dur   = 8'd4;
    clr_n = 1'b1;
    measure(3, 4, "R5");

    // R6: zero duration gives no pulse, then a one-cycle pulse
    cur_req = "R6";
    gate_hi = 1'b0;
    wait_n(4);
    dur     = 8'd0;
    gate_hi = 1'b1;
    measure(0, 0, "R6");
    gate_hi = 1'b0;
    wait_n(4);
    dur     = 8'd1;
    gate_hi = 1'b1;
    measure(3, 1, "R6");

    // R7: second trigger at n=4 while high; expect rise at 3, high until 12
    cur_req = "R7";
    gate_hi = 1'b0;
    wait_n(4);
    dur     = 8'd6;
    gate_hi = 1'b1;
    first = -1;
    cnt   = 0;
    for (int n = 1; n <= 16; n++) begin
      @(negedge clk);
      if (pulse_o) begin
        cnt++;
        if (first < 0) first = n;
      end
      if (n == 3) gate_hi = 1'b0;
      if (n == 4) gate_hi = 1'b1;
    end
    chk(first == 3, "R7", first, 3);
    chk(cnt == 10, "R7", cnt, 10);

    // R8: clear at n=4 truncates a 10-cycle pulse to 4 cycles
    cur_req = "R8";
    gate_hi = 1'b0;
    wait_n(4);
    dur     = 8'd10;
    gate_hi = 1'b1;
    cnt = 0;
    for (int n = 1; n <= 16; n++) begin
      @(negedge clk);
      if (pulse_o) cnt++;
      if (n == 4) clr_n = 1'b0;
    end
    chk(cnt == 4, "R8", cnt, 4);
    // gate edges while clear held low start nothing
    gate_hi = 1'b0;
    wait_n(3);
    gate_hi = 1'b1;
    measure(0, 0, "R8");
    clr_n = 1'b1;
    wait_n(20);

    // R8: trigger edge and clear together -> no pulse
    gate_hi = 1'b0;
    wait_n(5);
    gate_hi = 1'b1;
    clr_n   = 1'b0;
    measure(0, 0, "R8");
    clr_n = 1'b1;
    wait_n(20);

    // R9: low gate held high blocks high-gate and clear activity
    cur_req = "R9";
    gate_lo = 1'b1;
    wait_n(4);
    gate_hi = 1'b0;
    wait_n(3);
    gate_hi = 1'b1;
    measure(0, 0, "R9");
    clr_n = 1'b0;
    wait_n(3);
    clr_n = 1'b1;
    measure(0, 0, "R9");
    gate_lo = 1'b0;
    wait_n(20);

    // Random mix, compared cycle by cycle against the model
    cur_req = "R7";
    begin
      int unsigned seed_v;
      seed_v = $urandom(32'd20417);
      for (int n = 0; n < 4000; n++) begin
        @(negedge clk);
        if ($urandom_range(5) == 0) gate_lo = ~gate_lo;
        if ($urandom_range(4) == 0) gate_hi = ~gate_hi;
        if (clr_n ? ($urandom_range(15) == 0) : ($urandom_range(3) == 0)) clr_n = ~clr_n;
        if ($urandom_range(7) == 0) dur = DUR_W'($urandom_range(12));
      end
    end
    wait_n(20);

    summary();
    $finish;
  end

endmodule